// File: doc/BRIEF.md
# Private Peripheral Window Router

This block sits in front of the private peripherals of a cluster of up to four cores. It watches an 8 KB window. For each request it picks exactly one target: the control-unit register block, one core's interrupt CPU interface, one core's timer, one core's watchdog, or the shared interrupt distributor. It drives that target's select line and passes on an offset that is local to the selected region. Read data from the selected target comes straight back in the same cycle. The request carries the requesting core's ID. The ID matters for the "own core" alias page, which gives every core the same address for its own interrupt interface, and for the alias timer page, which does the same for its own timer and watchdog. Explicit per-core pages follow each alias.

Requests use a valid/ready handshake. The requester holds `req_addr` and `req_cpu` steady while `req_valid` is high and `req_ready` is low. The request is accepted on the clock edge where both are high. For a decoded request, `req_ready` follows the selected target's `tgt_ready`, so the target can apply back-pressure. An undecoded request is accepted at once, reads zero and raises a one-cycle error pulse.

The block also maps each core's timer and watchdog interrupt outputs onto that core's bank of 32 private interrupt lines.

Top module: `mpwin_router`

## Requirements
- R1: Window offsets 0x000 to 0x0FF select the control unit (`scu_sel`), and `tgt_offset` equals the address bits [7:0].
- R2: Page 0x1 (0x100 to 0x1FF) selects the interrupt CPU interface of the requesting core (`gicc_sel[req_cpu]`). `tgt_offset` equals address bits [7:0].
- R3: Page 0x2+k selects the interrupt CPU interface of core k, for k < NCPU. `tgt_offset` equals address bits [7:0].
- R4: Page 0x6+i selects a timer when its page offset is below 0x20. For i = 0 that is the requesting core's timer, and for i = k+1 it is core k's timer (`tmr_sel`). `tgt_offset` equals the page offset.
- R5: In the same pages, page offsets 0x20 to 0x3F select the matching watchdog (`wdg_sel`). `tgt_offset` equals the page offset minus 0x20.
- R6: Addresses 0x1000 to 0x1FFF select the distributor (`dist_sel`). `tgt_offset` equals the address minus 0x1000.
- R7: Some requests are undecoded: a core ID at or above NCPU (given on an alias page or implied by an explicit page), a timer-page offset of 0x40 or more, and any other page below 0x1000. For these no select is raised, `rsp_rdata` is zero and `req_ready` is high. `dec_err` is high for exactly the cycle after such a request.
- R8: The selects are one-hot. All selects and `rsp_rdata` are zero while `req_valid` is low.
- R9: `rsp_rdata` equals the read data of the selected target in the same cycle.
- R10: For a decoded request, `req_ready` equals `tgt_ready`.
- R11: Line 32k+29 of `ppi_out` equals `tmr_irq[k]` and line 32k+30 equals `wdg_irq[k]`. All other lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge |
| req_addr | input | 13 | Window offset |
| req_cpu | input | CW | Requesting core ID |
| tgt_ready | input | 1 | Selected target can take the access |
| tgt_offset | output | 13 | Offset local to the selected region |
| scu_sel | output | 1 | Control-unit select |
| scu_rdata | input | 32 | Control-unit read data |
| gicc_sel | output | NCPU | Per-core interrupt interface selects |
| gicc_rdata | input | 32*NCPU | Interrupt interface read data, core k at [32k+:32] |
| tmr_sel | output | NCPU | Per-core timer selects |
| tmr_rdata | input | 32*NCPU | Timer read data |
| wdg_sel | output | NCPU | Per-core watchdog selects |
| wdg_rdata | input | 32*NCPU | Watchdog read data |
| dist_sel | output | 1 | Distributor select |
| dist_rdata | input | 32 | Distributor read data |
| rsp_rdata | output | 32 | Returned read data |
| dec_err | output | 1 | Undecoded-access pulse |
| tmr_irq | input | NCPU | Timer interrupt per core |
| wdg_irq | input | NCPU | Watchdog interrupt per core |
| ppi_out | output | 32*NCPU | Private interrupt lines, core k at [32k+:32] |

## Verification
The hardest cases to reach are at the edge of the core count. The most delicate is an alias-page request from a core ID that exists on the bus but not in the cluster, together with the explicit pages just past the last core. These land on pages that would otherwise belong to a neighbouring region. The bench builds the router with three cores and a two-bit ID, which makes ID 3 and the first page past each per-core range reachable. Directed accesses hit each region boundary. Random addresses, IDs and ready levels then cover the rest.

// File: rtl/mpwin_pkg.sv
package mpwin_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_SCU  = 3'd1,
    TGT_GICC = 3'd2,
    TGT_TMR  = 3'd3,
    TGT_WDG  = 3'd4,
    TGT_DIST = 3'd5
  } tgt_e;
endpackage

// File: rtl/mpwin_addr_decode.sv
module mpwin_addr_decode
  import mpwin_pkg::*;
#(
  parameter int NCPU    = 4,
  parameter int AW      = 13,
  parameter int CW      = 2,
  parameter int PAGE_W  = 8,
  parameter int SLOT_W  = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cpu,
  output tgt_e          tgt,
  output logic [CW-1:0] bank,
  output logic [AW-1:0] offset
);
  localparam int ALIAS_PG = 1;
  localparam int EXPL_PG  = 2;
  localparam int TMR_PG   = 6;
  localparam int PG_BITS  = AW - 1 - PAGE_W;

  int page;
  int idx;
  int owner;

  always_comb begin
    tgt    = TGT_NONE;
    bank   = '0;
    offset = '0;
    page   = int'(addr[AW-2:PAGE_W]);
    idx    = 0;
    owner  = 0;
    if (addr[AW-1]) begin
      tgt    = TGT_DIST;
      offset = {1'b0, addr[AW-2:0]};
    end else if (page == 0) begin
      tgt                 = TGT_SCU;
      offset[PAGE_W-1:0]  = addr[PAGE_W-1:0];
    end else if (page == ALIAS_PG) begin
      if (int'(cpu) < NCPU) begin
        tgt                = TGT_GICC;
        bank               = cpu;
        offset[PAGE_W-1:0] = addr[PAGE_W-1:0];
      end
    end else if (page >= EXPL_PG && page < EXPL_PG + NCPU) begin
      tgt                = TGT_GICC;
      bank               = CW'(page - EXPL_PG);
      offset[PAGE_W-1:0] = addr[PAGE_W-1:0];
    end else if (page >= TMR_PG && page <= TMR_PG + NCPU) begin
      idx   = page - TMR_PG;
      owner = (idx == 0) ? int'(cpu) : idx - 1;
      if (owner < NCPU) begin
        bank = CW'(owner);
        offset[SLOT_W-1:0] = addr[SLOT_W-1:0];
        case (addr[PAGE_W-1:SLOT_W])
          '0:      tgt = TGT_TMR;
          'd1:     tgt = TGT_WDG;
          default: begin
            tgt    = TGT_NONE;
            offset = '0;
          end
        endcase
      end
    end
  end

  logic unused_pg;
  assign unused_pg = (PG_BITS < 1);
endmodule

// File: rtl/mpwin_rdata_mux.sv
module mpwin_rdata_mux
  import mpwin_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int CW   = 2,
  parameter int DW   = 32
) (
  input  logic               valid,
  input  tgt_e               tgt,
  input  logic [CW-1:0]      bank,
  input  logic [DW-1:0]      scu_rdata,
  input  logic [DW*NCPU-1:0] gicc_rdata,
  input  logic [DW*NCPU-1:0] tmr_rdata,
  input  logic [DW*NCPU-1:0] wdg_rdata,
  input  logic [DW-1:0]      dist_rdata,
  output logic [DW-1:0]      rdata
);
  int b;
  always_comb begin
    rdata = '0;
    b     = int'(bank);
    if (valid && b < NCPU) begin
      case (tgt)
        TGT_SCU:  rdata = scu_rdata;
        TGT_DIST: rdata = dist_rdata;
        TGT_GICC: rdata = gicc_rdata[b*DW +: DW];
        TGT_TMR:  rdata = tmr_rdata[b*DW +: DW];
        TGT_WDG:  rdata = wdg_rdata[b*DW +: DW];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mpwin_irq_route.sv
module mpwin_irq_route #(
  parameter int NCPU     = 4,
  parameter int LINES    = 32,
  parameter int TMR_LINE = 29,
  parameter int WDG_LINE = 30
) (
  input  logic [NCPU-1:0]       tmr_irq,
  input  logic [NCPU-1:0]       wdg_irq,
  output logic [LINES*NCPU-1:0] ppi_out
);
  for (genvar k = 0; k < NCPU; k++) begin : g_core
    logic [LINES-1:0] lines;
    always_comb begin
      lines           = '0;
      lines[TMR_LINE] = tmr_irq[k];
      lines[WDG_LINE] = wdg_irq[k];
    end
    assign ppi_out[k*LINES +: LINES] = lines;
  end
endmodule

// File: rtl/mpwin_router.sv
module mpwin_router
  import mpwin_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int AW       = 13,
  parameter int DW       = 32,
  parameter int LINES    = 32,
  parameter int TMR_LINE = 29,
  parameter int WDG_LINE = 30,
  parameter int CW       = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_addr,
  input  logic [CW-1:0]         req_cpu,
  input  logic                  tgt_ready,
  output logic [AW-1:0]         tgt_offset,
  output logic                  scu_sel,
  input  logic [DW-1:0]         scu_rdata,
  output logic [NCPU-1:0]       gicc_sel,
  input  logic [DW*NCPU-1:0]    gicc_rdata,
  output logic [NCPU-1:0]       tmr_sel,
  input  logic [DW*NCPU-1:0]    tmr_rdata,
  output logic [NCPU-1:0]       wdg_sel,
  input  logic [DW*NCPU-1:0]    wdg_rdata,
  output logic                  dist_sel,
  input  logic [DW-1:0]         dist_rdata,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  dec_err,
  input  logic [NCPU-1:0]       tmr_irq,
  input  logic [NCPU-1:0]       wdg_irq,
  output logic [LINES*NCPU-1:0] ppi_out
);
  tgt_e          tgt;
  logic [CW-1:0] bank;
  logic [AW-1:0] offset;
  logic          miss;

  mpwin_addr_decode #(.NCPU(NCPU), .AW(AW), .CW(CW)) u_dec (
    .addr(req_addr), .cpu(req_cpu), .tgt(tgt), .bank(bank), .offset(offset)
  );

  assign miss       = (tgt == TGT_NONE);
  assign tgt_offset = req_valid ? offset : '0;
  assign scu_sel    = req_valid && (tgt == TGT_SCU);
  assign dist_sel   = req_valid && (tgt == TGT_DIST);
  assign req_ready  = miss ? 1'b1 : tgt_ready;

  for (genvar b = 0; b < NCPU; b++) begin : g_sel
    logic mine;
    assign mine        = req_valid && (bank == CW'(b));
    assign gicc_sel[b] = mine && (tgt == TGT_GICC);
    assign tmr_sel[b]  = mine && (tgt == TGT_TMR);
    assign wdg_sel[b]  = mine && (tgt == TGT_WDG);
  end

  mpwin_rdata_mux #(.NCPU(NCPU), .CW(CW), .DW(DW)) u_mux (
    .valid(req_valid), .tgt(tgt), .bank(bank),
    .scu_rdata(scu_rdata), .gicc_rdata(gicc_rdata), .tmr_rdata(tmr_rdata),
    .wdg_rdata(wdg_rdata), .dist_rdata(dist_rdata), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_err <= 1'b0;
    else        dec_err <= req_valid && miss;
  end

  mpwin_irq_route #(.NCPU(NCPU), .LINES(LINES), .TMR_LINE(TMR_LINE),
                    .WDG_LINE(WDG_LINE)) u_irq (
    .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .ppi_out(ppi_out)
  );
endmodule

// File: rtl/mpwin_router_chk.sv
module mpwin_router_chk #(
  parameter int NCPU     = 4,
  parameter int DW       = 32,
  parameter int LINES    = 32,
  parameter int TMR_LINE = 29,
  parameter int WDG_LINE = 30
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  tgt_ready,
  input logic                  scu_sel,
  input logic [NCPU-1:0]       gicc_sel,
  input logic [NCPU-1:0]       tmr_sel,
  input logic [NCPU-1:0]       wdg_sel,
  input logic                  dist_sel,
  input logic [DW-1:0]         rsp_rdata,
  input logic                  dec_err,
  input logic [NCPU-1:0]       tmr_irq,
  input logic [NCPU-1:0]       wdg_irq,
  input logic [LINES*NCPU-1:0] ppi_out
);
  logic [3*NCPU+1:0] all_sel;
  logic              none;
  assign all_sel = {scu_sel, dist_sel, gicc_sel, tmr_sel, wdg_sel};
  assign none    = (all_sel == '0);

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(all_sel));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (none && rsp_rdata == '0));
  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && none) |-> (rsp_rdata == '0 && req_ready));
  // R7
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && none) |=> dec_err);
  // R7
  hit_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && none) |=> !dec_err);
  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !none) |-> (req_ready == tgt_ready));

  for (genvar k = 0; k < NCPU; k++) begin : g_irq
    // R11
    tmr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ppi_out[k*LINES+TMR_LINE] == tmr_irq[k]);
    // R11
    wdg_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ppi_out[k*LINES+WDG_LINE] == wdg_irq[k]);
  end
endmodule

bind mpwin_router mpwin_router_chk #(
  .NCPU(NCPU), .DW(DW), .LINES(LINES), .TMR_LINE(TMR_LINE), .WDG_LINE(WDG_LINE)
) u_chk (.*);

// File: tb/mpwin_router_test.sv
module mpwin_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int CW = 2;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [12:0]     req_addr = '0;
  logic [CW-1:0]   req_cpu = '0;
  logic            tgt_ready = 1'b1;
  logic [12:0]     tgt_offset;
  logic            scu_sel, dist_sel;
  logic [N-1:0]    gicc_sel, tmr_sel, wdg_sel;
  logic [DW-1:0]   scu_rdata = 32'h5C5C0000;
  logic [DW-1:0]   dist_rdata = 32'hD1570000;
  logic [DW*N-1:0] gicc_rdata, tmr_rdata, wdg_rdata;
  logic [DW-1:0]   rsp_rdata;
  logic            dec_err;
  logic [N-1:0]    tmr_irq = '0, wdg_irq = '0;
  logic [32*N-1:0] ppi_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpwin_router #(.NCPU(N), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cpu(req_cpu), .tgt_ready(tgt_ready),
    .tgt_offset(tgt_offset), .scu_sel(scu_sel), .scu_rdata(scu_rdata),
    .gicc_sel(gicc_sel), .gicc_rdata(gicc_rdata), .tmr_sel(tmr_sel),
    .tmr_rdata(tmr_rdata), .wdg_sel(wdg_sel), .wdg_rdata(wdg_rdata),
    .dist_sel(dist_sel), .dist_rdata(dist_rdata), .rsp_rdata(rsp_rdata),
    .dec_err(dec_err), .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .ppi_out(ppi_out)
  );

  // Expected target: 0 none, 1 control, 2 irq iface, 3 timer, 4 watchdog, 5 distributor
  function automatic void model(input logic [12:0] a, input int c,
                                output int t, output int b, output int off);
    int pg, po, own;
    t = 0; b = 0; off = 0;
    pg = int'(a[11:8]); po = int'(a[7:0]);
    if (a >= 13'h1000) begin t = 5; off = int'(a) - 'h1000; end
    else if (pg == 0) begin t = 1; off = po; end
    else if (pg == 1) begin if (c < N) begin t = 2; b = c; off = po; end end
    else if (pg >= 2 && pg - 2 < N) begin t = 2; b = pg - 2; off = po; end
    else if (pg >= 6 && pg - 6 <= N) begin
      own = (pg == 6) ? c : pg - 7;
      if (own < N) begin
        if (po < 'h20)      begin t = 3; b = own; off = po; end
        else if (po < 'h40) begin t = 4; b = own; off = po - 'h20; end
      end
    end
  endfunction

  function automatic string tag(input int t);
    case (t)
      1: return "R1"; 2: return "R2/R3"; 3: return "R4"; 4: return "R5";
      5: return "R6"; default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic access(input logic [12:0] a, input int c, input bit rdy);
    int t, b, off;
    logic [3*N+1:0] exp_sel, act_sel;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cpu = CW'(c); tgt_ready = rdy;
    model(a, c, t, b, off);
    exp_sel = '0; exp_rd = '0;
    case (t)
      1: begin exp_sel[3*N+1] = 1'b1; exp_rd = scu_rdata; end
      5: begin exp_sel[3*N] = 1'b1; exp_rd = dist_rdata; end
      2: begin exp_sel[2*N+b] = 1'b1; exp_rd = 32'hC1000000 + DW'(b); end
      3: begin exp_sel[N+b] = 1'b1; exp_rd = 32'h71000000 + DW'(b); end
      4: begin exp_sel[b] = 1'b1; exp_rd = 32'hAD000000 + DW'(b); end
      default: ;
    endcase
    #1;
    act_sel = {scu_sel, dist_sel, gicc_sel, tmr_sel, wdg_sel};
    check(act_sel == exp_sel, tag(t), $sformatf("select @%0h cpu%0d", a, c),
          64'(act_sel), 64'(exp_sel));
    if (t != 0)
      check(tgt_offset == 13'(off), tag(t), "offset", 64'(tgt_offset), 64'(off));
    // R9: read data of the selected target
    check(rsp_rdata == exp_rd, (t == 0) ? "R7" : "R9", "rdata",
          64'(rsp_rdata), 64'(exp_rd));
    // R10: ready follows target, or is high on a miss
    check(req_ready == ((t == 0) ? 1'b1 : rdy), (t == 0) ? "R7" : "R10",
          "req_ready", 64'(req_ready), 64'((t == 0) ? 1'b1 : rdy));
    @(posedge clk); #1;
    // R7: error pulse the cycle after an undecoded request
    check(dec_err == (t == 0), "R7", "dec_err", 64'(dec_err), 64'(t == 0));
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0; req_addr = 13'h0100; req_cpu = '0;
    #1;
    // R8: nothing selected when idle
    check({scu_sel, dist_sel, gicc_sel, tmr_sel, wdg_sel} == '0 && rsp_rdata == '0,
          "R8", "idle select", 64'({scu_sel, dist_sel, gicc_sel, tmr_sel, wdg_sel}), 64'd0);
    @(posedge clk); #1;
    check(dec_err == 1'b0, "R8", "idle dec_err", 64'(dec_err), 64'd0);
  endtask

  task automatic irq_check(input logic [N-1:0] ti, input logic [N-1:0] wi);
    logic [32*N-1:0] exp;
    @(negedge clk);
    tmr_irq = ti; wdg_irq = wi;
    exp = '0;
    for (int k = 0; k < N; k++) begin
      exp[32*k+29] = ti[k];
      exp[32*k+30] = wi[k];
    end
    #1;
    check(ppi_out == exp, "R11", "ppi_out", 64'(ppi_out), 64'(exp));
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      gicc_rdata[k*DW +: DW] = 32'hC1000000 + DW'(k);
      tmr_rdata[k*DW +: DW]  = 32'h71000000 + DW'(k);
      wdg_rdata[k*DW +: DW]  = 32'hAD000000 + DW'(k);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check(dec_err == 1'b0 && req_ready == 1'b1 && scu_sel == 1'b0, "R8", "reset state",
          64'({dec_err, req_ready, scu_sel}), 64'b010);
    rst_n = 1'b1;
    idle_check();
    // directed boundaries
    access(13'h0000, 0, 1);  access(13'h00FF, 2, 1);       // R1
    access(13'h0100, 0, 1);  access(13'h01FF, 2, 1);       // R2
    access(13'h0144, 3, 1);                                // R7 alias, absent core
    access(13'h0200, 1, 1);  access(13'h04FC, 0, 1);       // R3
    access(13'h0500, 0, 1);                                // R7 page past last core
    access(13'h0600, 1, 1);  access(13'h061F, 2, 0);       // R4 alias
    access(13'h0620, 0, 1);  access(13'h063F, 1, 1);       // R5 alias
    access(13'h0640, 0, 1);                                // R7 slot hole
    access(13'h0604, 3, 1);                                // R7 alias timer absent core
    access(13'h0908, 0, 1);  access(13'h0924, 0, 1);       // R4/R5 core 2
    access(13'h0A00, 0, 1);  access(13'h0FFF, 1, 1);       // R7 holes
    access(13'h1000, 0, 1);  access(13'h1FFF, 2, 0);       // R6
    idle_check();
    irq_check(3'b000, 3'b000); irq_check(3'b101, 3'b010);
    irq_check(3'b010, 3'b111);
    // random mix
    for (int i = 0; i < 400; i++)
      access(13'($urandom_range(0, 13'h1FFF)), int'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)));
    for (int i = 0; i < 20; i++)
      irq_check(N'($urandom), N'($urandom));
    idle_check();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule